// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a 64-word first-in/first-out buffer whose write and read sides are paced by level strobes instead of enables. A producer raises the shift-in strobe while the input-ready flag is high; the word on the data inputs is stored and input-ready drops. When the strobe returns low, the write pointer moves on and input-ready comes back, unless the buffer is now full. A consumer handles the output side the same way. Raising shift-out while output-ready is high clears output-ready and keeps the current word on the outputs. Lowering shift-out releases that word, and the next stored word falls through to the outputs with output-ready high.

Both strobes are sampled on one system clock through two-flop synchronizers, so they can come from logic that is not tied to that clock. An active-low master reset empties the buffer and clears the outputs. An active-low output enable either drives the data pins or leaves them at high impedance. The word width is a parameter, meant to be 4 or 5 bits.

Top module: `hs_fifo`

## Requirements
- R1: While `mrN` is low and right after it rises (with `shiftIn` low), `inReady` is 1, `outReady` is 0 and the output word is all zeros.
- R2: A write takes place when the synchronized `shiftIn` is high and `inReady` is high. `inReady` is low from the next cycle until `shiftIn` has gone low. It is high again once the low level is seen, provided fewer than 64 words are stored.
- R3: With 64 words stored, `inReady` stays low. A `shiftIn` pulse that begins and ends while the buffer is full stores nothing.
- R4: If `shiftIn` is held high while the buffer is full, a read that frees a location makes `inReady` high for exactly one cycle. The waiting word is stored in that cycle, and `inReady` stays low until `shiftIn` falls.
- R5: Raising `shiftOut` while `outReady` is high makes `outReady` low and leaves the output word unchanged. When `shiftOut` goes low, the next stored word appears with `outReady` high. The output word never changes while `outReady` stays high.
- R6: When the buffer is empty, `outReady` stays low and the last word read stays on the outputs. A `shiftOut` pulse given while `outReady` is low is ignored.
- R7: For a word written into an empty buffer, `outReady` rises on the fourth clock edge after the raw `shiftIn` falls: two synchronizer edges, one commit edge and one load edge.
- R8: With `shiftOut` held high and the buffer empty, a written word makes `outReady` high for exactly one cycle and then stays on the outputs. A second word is not presented until `shiftOut` goes low.
- R9: If `shiftIn` is high when `mrN` is released, the input word is stored and `inReady` stays low until `shiftIn` falls. If `shiftIn` is low at release, `inReady` is high and nothing is stored.
- R10: While `outEnN` is 1, every bit of `dataOut` is high impedance.
- R11: Words leave in the order they were written, including runs where a read and a write strobe are raised and lowered together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| mrN | input | 1 | Active-low master reset, asynchronous assert |
| shiftIn | input | 1 | Write strobe; high stores, low advances |
| shiftOut | input | 1 | Read strobe; high releases, low advances |
| dataIn | input | WIDTH | Word to be written, held stable while shiftIn is high |
| outEnN | input | 1 | Active-low output enable for dataOut |
| dataOut | output | WIDTH | Current output word, or high impedance |
| inReady | output | 1 | High when a write strobe will be accepted |
| outReady | output | 1 | High when dataOut holds a valid, unread word |

## Verification
The bench goes after the full boundary. A design that counts a word still held at the output as free space would accept a 65th word. One that reacts to a shift-in pulse given while full would later emit a word that was never accepted. With shift-in held across a read from a full buffer, a wrong design either loses the waiting word or stores it twice, which shows up as a missing or repeated word in the drain order. On the empty side, the bench holds shift-out high while words arrive. A design that presents the second word too early shows it before shift-out falls. One that acts on a strobe given while empty skips a word later on. The two reset-release cases catch a design that loses, or invents, a write when shift-in is already high as reset ends.

// File: rtl/hs_fifo_pkg.sv
package hs_fifo_pkg;
  typedef struct packed {
    logic memWrite;
    logic wrAdvance;
    logic rdAdvance;
    logic loadOut;
  } fifoStrobe_t;
endpackage

// File: rtl/hs_fifo_sync.sv
module hs_fifo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/hs_fifo_ctrl.sv
module hs_fifo_ctrl
  import hs_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             siSync,
  input  logic             soSync,
  output fifoStrobe_t      strobe,
  output logic             inReady,
  output logic             outReady,
  output logic [CNT_W-1:0] occupancy
);
  logic wrHold;
  logic rdHold;
  logic takeOut;

  // write side: store on high level, commit on low level
  assign inReady          = !wrHold && (occupancy < CNT_W'(DEPTH));
  assign strobe.memWrite  = siSync && inReady;
  assign strobe.wrAdvance = wrHold && !siSync;

  // read side: release on high level, advance on low level
  assign takeOut          = soSync && outReady;
  assign strobe.rdAdvance = rdHold && !soSync;
  assign strobe.loadOut   = !outReady && !rdHold && (occupancy != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrHold    <= 1'b0;
      rdHold    <= 1'b0;
      outReady  <= 1'b0;
      occupancy <= '0;
    end else begin
      if (strobe.memWrite)       wrHold <= 1'b1;
      else if (strobe.wrAdvance) wrHold <= 1'b0;

      if (takeOut)               rdHold <= 1'b1;
      else if (strobe.rdAdvance) rdHold <= 1'b0;

      if (strobe.loadOut)        outReady <= 1'b1;
      else if (takeOut)          outReady <= 1'b0;

      occupancy <= occupancy + CNT_W'(strobe.wrAdvance) - CNT_W'(strobe.rdAdvance);
    end
  end
endmodule

// File: rtl/hs_fifo_datapath.sv
module hs_fifo_datapath
  import hs_fifo_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] qWord
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.memWrite) mem[wrPtr] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      qWord <= '0;
    end else begin
      if (strobe.wrAdvance) wrPtr <= nextPtr(wrPtr);
      if (strobe.rdAdvance) rdPtr <= nextPtr(rdPtr);
      if (strobe.loadOut)   qWord <= mem[rdPtr];
    end
  end
endmodule

// File: rtl/hs_fifo.sv
module hs_fifo
  import hs_fifo_pkg::*;
#(
  parameter int WIDTH       = 5,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             mrN,
  input  logic             shiftIn,
  input  logic             shiftOut,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             outEnN,
  output logic [WIDTH-1:0] dataOut,
  output logic             inReady,
  output logic             outReady
);
  fifoStrobe_t      strobe;
  logic             siSync;
  logic             soSync;
  logic [CNT_W-1:0] occupancy;
  logic [WIDTH-1:0] qWord;

  hs_fifo_sync #(.STAGES(SYNC_STAGES)) siSync_i (
    .clk(clk), .rstN(mrN), .asyncIn(shiftIn), .syncOut(siSync));

  hs_fifo_sync #(.STAGES(SYNC_STAGES)) soSync_i (
    .clk(clk), .rstN(mrN), .asyncIn(shiftOut), .syncOut(soSync));

  hs_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(mrN), .siSync(siSync), .soSync(soSync),
    .strobe(strobe), .inReady(inReady), .outReady(outReady),
    .occupancy(occupancy));

  hs_fifo_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(mrN), .strobe(strobe), .dataIn(dataIn), .qWord(qWord));

  assign dataOut = outEnN ? {WIDTH{1'bz}} : qWord;
endmodule

// File: rtl/hs_fifo_chk.sv
module hs_fifo_chk
  import hs_fifo_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             mrN,
  input logic             inReady,
  input logic             outReady,
  input logic [CNT_W-1:0] occupancy,
  input logic [WIDTH-1:0] qWord,
  input fifoStrobe_t      strobe
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !mrN |-> (inReady && !outReady && qWord == '0));

  assert_write_drops_ready_R2: assert property (@(posedge clk) disable iff (!mrN)
    strobe.memWrite |=> !inReady);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!mrN)
    occupancy <= CNT_W'(DEPTH));

  assert_word_stable_R5: assert property (@(posedge clk) disable iff (!mrN)
    (outReady && $past(outReady)) |-> $stable(qWord));

  assert_advance_while_busy_R5: assert property (@(posedge clk) disable iff (!mrN)
    strobe.rdAdvance |-> !outReady);

  assert_valid_has_data_R7: assert property (@(posedge clk) disable iff (!mrN)
    $rose(outReady) |-> occupancy != '0);
endmodule

bind hs_fifo hs_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .mrN(mrN), .inReady(inReady), .outReady(outReady),
  .occupancy(occupancy), .qWord(qWord), .strobe(strobe));

// File: tb/hs_fifo_tb_top.sv
`timescale 1ns/1ps
module hs_fifo_tb_top;
  localparam int WIDTH = 5;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic mrN = 1'b0;
  logic shiftIn = 1'b0;
  logic shiftOut = 1'b0;
  logic outEnN = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic [WIDTH-1:0] dataOut;
  logic inReady;
  logic outReady;

  int nChecks = 0;
  int nFail = 0;
  bit summaryDone = 1'b0;
  logic [WIDTH-1:0] model[$];

  // stimulus table: [6:5] kind (0 write, 1 read, 2 read+write), [4:0] word
  localparam logic [6:0] VEC [16] = '{
    7'h01, 7'h12, 7'h03, 7'h20, 7'h54, 7'h1A, 7'h20, 7'h45,
    7'h5F, 7'h00, 7'h20, 7'h20, 7'h15, 7'h4A, 7'h20, 7'h20};

  always #4 clk = ~clk;

  hs_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .mrN(mrN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .dataIn(dataIn), .outEnN(outEnN), .dataOut(dataOut),
    .inReady(inReady), .outReady(outReady));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic printSummary();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    end
  endtask

  task automatic waitFlag(input bit wantOut);
    for (int i = 0; i < 40; i++) begin
      if (wantOut ? outReady : inReady) break;
      tick(1);
    end
  endtask

  task automatic pushWord(input logic [WIDTH-1:0] d);
    waitFlag(1'b0);
    check(inReady === 1'b1, "R2 ready before write", int'(inReady), 1);
    dataIn = d;
    shiftIn = 1'b1;
    tick(4);
    check(inReady === 1'b0, "R2 ready low while strobe high", int'(inReady), 0);
    shiftIn = 1'b0;
    model.push_back(d);
    tick(4);
    if (model.size() < DEPTH)
      check(inReady === 1'b1, "R2 ready back after strobe low", int'(inReady), 1);
    else
      check(inReady === 1'b0, "R3 ready low when full", int'(inReady), 0);
  endtask

  task automatic popWord();
    logic [WIDTH-1:0] held;
    waitFlag(1'b1);
    check(outReady === 1'b1, "R5 output valid", int'(outReady), 1);
    check(dataOut === model[0], "R11 word order", int'(dataOut), int'(model[0]));
    held = dataOut;
    shiftOut = 1'b1;
    tick(4);
    check(outReady === 1'b0 && dataOut === held, "R5 released word held",
          int'({outReady, dataOut}), int'({1'b0, held}));
    shiftOut = 1'b0;
    void'(model.pop_front());
    tick(6);
    if (model.size() > 0)
      check(outReady === 1'b1 && dataOut === model[0], "R5 next word presented",
            int'({outReady, dataOut}), int'({1'b1, model[0]}));
    else
      check(outReady === 1'b0 && dataOut === held, "R6 last word stays",
            int'({outReady, dataOut}), int'({1'b0, held}));
  endtask

  task automatic bothWord(input logic [WIDTH-1:0] d);
    for (int i = 0; i < 40; i++) begin
      if (outReady && inReady) break;
      tick(1);
    end
    check(dataOut === model[0], "R11 word before combined strobe", int'(dataOut), int'(model[0]));
    dataIn = d;
    shiftIn = 1'b1;
    shiftOut = 1'b1;
    tick(4);
    check(outReady === 1'b0 && inReady === 1'b0, "R11 both flags low",
          int'({outReady, inReady}), 0);
    shiftIn = 1'b0;
    shiftOut = 1'b0;
    void'(model.pop_front());
    model.push_back(d);
    tick(6);
    check(outReady === 1'b1 && dataOut === model[0], "R11 combined strobe order",
          int'({outReady, dataOut}), int'({1'b1, model[0]}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    printSummary();
    $finish;
  end

  initial begin
    int pulses;
    logic [WIDTH-1:0] last;

    // R1 reset state
    tick(3);
    check(inReady === 1'b1 && outReady === 1'b0, "R1 flags during reset",
          int'({inReady, outReady}), 2);
    mrN = 1'b1;
    tick(2);
    check(inReady === 1'b1 && outReady === 1'b0 && dataOut === '0, "R1 state after reset",
          int'({inReady, outReady, dataOut}), int'({2'b10, 5'h00}));

    // R10 high impedance
    outEnN = 1'b1;
    tick(1);
    check(dataOut === 5'bzzzzz, "R10 outputs released", int'(dataOut), 0);
    outEnN = 1'b0;
    tick(1);

    // table walk (R2, R5, R11)
    foreach (VEC[i]) begin
      case (VEC[i][6:5])
        2'd0:    pushWord(VEC[i][4:0]);
        2'd1:    popWord();
        default: bothWord(VEC[i][4:0]);
      endcase
    end

    // R3 fill to the top
    for (int i = 0; i < DEPTH; i++) pushWord(WIDTH'(i + 3));
    check(inReady === 1'b0, "R3 full flag", int'(inReady), 0);
    dataIn = 5'h1F;
    shiftIn = 1'b1;
    tick(4);
    shiftIn = 1'b0;
    tick(4);
    check(inReady === 1'b0, "R3 pulse while full", int'(inReady), 0);

    // R4 strobe held across a read from full
    dataIn = 5'h0B;
    shiftIn = 1'b1;
    tick(4);
    check(dataOut === model[0], "R11 head before read", int'(dataOut), int'(model[0]));
    shiftOut = 1'b1;
    tick(4);
    shiftOut = 1'b0;
    void'(model.pop_front());
    pulses = 0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (inReady) pulses++;
    end
    check(pulses == 1, "R4 one-cycle ready pulse", pulses, 1);
    check(inReady === 1'b0, "R4 ready low with strobe held", int'(inReady), 0);
    model.push_back(5'h0B);
    shiftIn = 1'b0;
    tick(4);
    check(inReady === 1'b0, "R3 full again", int'(inReady), 0);

    // drain (R3 ignored word never appears, R11 order)
    while (model.size() > 0) popWord();
    last = dataOut;

    // R6 read strobe while empty is ignored
    shiftOut = 1'b1;
    tick(4);
    shiftOut = 1'b0;
    tick(4);
    check(outReady === 1'b0 && dataOut === last, "R6 empty read ignored",
          int'({outReady, dataOut}), int'({1'b0, last}));

    // R7 fall-through timing
    dataIn = 5'h16;
    shiftIn = 1'b1;
    tick(4);
    shiftIn = 1'b0;
    tick(3);
    check(outReady === 1'b0, "R7 not yet valid at edge 3", int'(outReady), 0);
    tick(1);
    check(outReady === 1'b1 && dataOut === 5'h16, "R7 valid at edge 4",
          int'({outReady, dataOut}), int'({1'b1, 5'h16}));
    model.push_back(5'h16);
    popWord();

    // R8 read strobe held while empty
    shiftOut = 1'b1;
    tick(4);
    dataIn = 5'h09;
    shiftIn = 1'b1;
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (outReady) pulses++;
    end
    shiftIn = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (outReady) pulses++;
    end
    check(pulses == 1, "R8 one-cycle valid pulse", pulses, 1);
    check(dataOut === 5'h09, "R8 word stays on outputs", int'(dataOut), 9);
    outEnN = 1'b1;
    tick(1);
    check(dataOut === 5'bzzzzz, "R10 released with data", int'(dataOut), 0);
    outEnN = 1'b0;
    model.push_back(5'h09);
    pushWord(5'h1C);
    tick(4);
    check(outReady === 1'b0 && dataOut === 5'h09, "R8 second word waits",
          int'({outReady, dataOut}), int'({1'b0, 5'h09}));
    shiftOut = 1'b0;
    void'(model.pop_front());
    tick(6);
    check(outReady === 1'b1 && dataOut === 5'h1C, "R8 second word after release",
          int'({outReady, dataOut}), int'({1'b1, 5'h1C}));
    popWord();

    // R9 reset released with write strobe high
    dataIn = 5'h13;
    shiftIn = 1'b1;
    mrN = 1'b0;
    model.delete();
    tick(3);
    mrN = 1'b1;
    tick(8);
    check(inReady === 1'b0, "R9 write at release", int'(inReady), 0);
    shiftIn = 1'b0;
    tick(6);
    check(outReady === 1'b1 && dataOut === 5'h13, "R9 released word stored",
          int'({outReady, dataOut}), int'({1'b1, 5'h13}));
    check(inReady === 1'b1, "R9 ready after strobe low", int'(inReady), 1);

    // R9 reset released with write strobe low
    mrN = 1'b0;
    tick(3);
    mrN = 1'b1;
    tick(8);
    check(inReady === 1'b1 && outReady === 1'b0 && dataOut === '0, "R9 nothing stored",
          int'({inReady, outReady, dataOut}), int'({2'b10, 5'h00}));

    printSummary();
    $finish;
  end
endmodule